// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps the time of day used to stamp packets: an unsigned seconds count and a sub-second count. Each time the counter steps, the sub-second count grows by a programmable increment. When it reaches the rollover limit, it wraps and carries one into the seconds. The limit is either one billion (one nanosecond per bit) or 2^31 (binary fraction, about 0.466 ns per bit).

The stepping rate has two modes. In coarse mode the counter steps on every clock. In fine mode a 32-bit addend is summed into a phase accumulator on every clock, and the counter steps only on the cycles where that sum carries out. Software trims the frequency by changing the addend.

Software reaches the block through a plain register-write port. That port holds staged seconds, staged sub-seconds, a staged addend and the increment. A control word holds the mode bits and three command bits that clear themselves: load the time, add or subtract an offset, and activate the staged addend.

Top module: `ptp_time_counter`

## Requirements
- R1: In fine mode (control bit 0 = 1) the active addend is added into a 32-bit accumulator on every clock. The time steps only on cycles where that addition carries out of bit 31; on other cycles seconds and sub-seconds hold.
- R2: With the active addend at 0x8000_0000 in fine mode, the time steps on every second clock.
- R3: In coarse mode (control bit 0 = 0), the sub-second count grows by the increment on every clock where no command is being applied.
- R4: With digital rollover (control bit 1 = 1), a step that makes the sub-second count reach 1,000,000,000 or more subtracts 1,000,000,000 from it and adds one to the seconds.
- R5: With binary rollover (control bit 1 = 0), a step that makes the sub-second count reach 2^31 or more subtracts 2^31 from it and adds one to the seconds.
- R6: Writing control (address 0) with bit 2 set loads the staged seconds (address 1) and the staged sub-seconds (address 2, bits 30:0) on the following clock edge. Pending bit 0 reads 1 for exactly the one cycle between the write and the load, then clears by itself. No step happens on the load edge.
- R7: Writing control with bit 4 set copies the staged addend (address 3) into the active addend on the following edge, and pending bit 2 clears by itself. A write to address 3 alone does not change the stepping rate.
- R8: Writing control with bit 3 set adds the staged seconds and sub-seconds to the running time on the following edge, with pending bit 1 high for one cycle. A sub-second sum at or above the rollover limit is brought back into range and carries one second.
- R9: When bit 31 of the staged sub-second word is 1, the update subtracts. The subtrahend is given as seconds = 2^32 − m_s and sub-seconds = limit − m_n. The result equals the true difference, with a borrow from the seconds.
- R10: The increment is the 8-bit field at bits 23:16 of address 4; the other bits of that word are ignored.
- R11: Seconds wrap modulo 2^32.
- R12: When several command bits are set in one control write, they all take effect on the same following edge. The time is loaded first, the offset is applied to the loaded value, and the addend copy happens as well.
- R13: Reset clears the time, the accumulator, the active addend, the increment and the pending bits. It leaves the counter in coarse mode with binary rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 seconds, 2 sub-seconds, 3 addend, 4 increment) |
| wr_data | input | 32 | Register write data |
| sec_o | output | 32 | Current seconds |
| subsec_o | output | 31 | Current sub-seconds |
| cmd_pending_o | output | 3 | Commands waiting to apply: bit 0 load, bit 1 offset, bit 2 addend |

## Verification
The bench builds the block with its default parameters: 32-bit seconds, 31-bit sub-seconds, a 32-bit accumulator, and an 8-bit increment at bits 23:16 with a one-billion digital limit. The mid-range addend gives a carry every second clock, so both fine-mode rates can be seen within a few cycles. Preloading the time just below either rollover limit, or at the top of the seconds range, reaches every wrap within a handful of steps. Random phases in all four mode combinations mix offset, load and addend commands against a bench model that keeps the time as one total count modulo 2^32 times the limit.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_SEC    = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_SUB    = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_ADDEND = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_INC    = 3'd4;

  localparam int unsigned CB_FINE   = 0;
  localparam int unsigned CB_DIG    = 1;
  localparam int unsigned CB_INIT   = 2;
  localparam int unsigned CB_UPD    = 3;
  localparam int unsigned CB_ADDEND = 4;

  // pending command set, bit order matches cmd_pending_o
  typedef struct packed {
    logic addend;
    logic upd;
    logic init;
  } cmd_t;
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned SUB_W   = 31,
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned INC_W   = 8,
  parameter int unsigned INC_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fine_q,
  output logic              dig_q,
  output logic [SEC_W-1:0]  stg_sec,
  output logic [SUB_W-1:0]  stg_sub,
  output logic              stg_neg,
  output logic [ACC_W-1:0]  stg_addend,
  output logic [INC_W-1:0]  inc_q,
  output cmd_t              pend_q
);
  localparam int unsigned NEG_BIT = DATA_W - 1;

  logic wr_ctrl;
  cmd_t cmd_wr;

  always_comb begin
    wr_ctrl       = wr_en && (wr_addr == ADDR_CTRL);
    cmd_wr.init   = wr_data[CB_INIT];
    cmd_wr.upd    = wr_data[CB_UPD];
    cmd_wr.addend = wr_data[CB_ADDEND];
  end

  // commands live for exactly one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      pend_q <= wr_ctrl ? cmd_wr : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fine_q     <= 1'b0;
      dig_q      <= 1'b0;
      stg_sec    <= '0;
      stg_sub    <= '0;
      stg_neg    <= 1'b0;
      stg_addend <= '0;
      inc_q      <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADDR_CTRL: begin
          fine_q <= wr_data[CB_FINE];
          dig_q  <= wr_data[CB_DIG];
        end
        ADDR_SEC:    stg_sec    <= wr_data[SEC_W-1:0];
        ADDR_SUB: begin
          stg_sub <= wr_data[SUB_W-1:0];
          stg_neg <= wr_data[NEG_BIT];
        end
        ADDR_ADDEND: stg_addend <= wr_data[ACC_W-1:0];
        ADDR_INC:    inc_q      <= wr_data[INC_LSB +: INC_W];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptp_tc_rate.sv
module ptp_tc_rate #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fine,
  input  logic             ld_addend,
  input  logic [ACC_W-1:0] stg_addend,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] act_q;
  logic [ACC_W:0]   acc_sum;

  always_comb begin
    acc_sum = {1'b0, acc_q} + {1'b0, act_q};
    tick    = fine ? acc_sum[ACC_W] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      act_q <= '0;
    end else begin
      acc_q <= acc_sum[ACC_W-1:0];
      if (ld_addend) act_q <= stg_addend;
    end
  end
endmodule

// File: rtl/ptp_tc_time.sv
module ptp_tc_time #(
  parameter int unsigned     SEC_W   = 32,
  parameter int unsigned     SUB_W   = 31,
  parameter int unsigned     INC_W   = 8,
  parameter longint unsigned DIG_LIM = 1000000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dig,
  input  logic [INC_W-1:0] inc,
  input  logic             tick,
  input  logic             ld_init,
  input  logic             ld_upd,
  input  logic [SEC_W-1:0] stg_sec,
  input  logic [SUB_W-1:0] stg_sub,
  input  logic             stg_neg,
  output logic [SEC_W-1:0] sec_q,
  output logic [SUB_W-1:0] sub_q
);
  localparam int unsigned    LW      = SUB_W + 1;
  localparam logic [LW-1:0]  LIM_DIG = LW'(DIG_LIM);
  localparam logic [LW-1:0]  LIM_BIN = {1'b1, {SUB_W{1'b0}}};

  logic [LW-1:0]    lim;
  logic [SEC_W-1:0] base_sec, off_sec, sec_fix;
  logic [SUB_W-1:0] base_sub, off_sub, tick_sub;
  logic [LW-1:0]    off_sum, tick_sum;
  logic             off_ovf, tick_ovf;

  always_comb begin
    lim      = dig ? LIM_DIG : LIM_BIN;
    // a load feeds the offset adder so both commands compose
    base_sec = ld_init ? stg_sec : sec_q;
    base_sub = ld_init ? stg_sub : sub_q;

    off_sum  = {1'b0, base_sub} + {1'b0, stg_sub};
    off_ovf  = off_sum >= lim;
    off_sub  = off_ovf ? SUB_W'(off_sum - lim) : SUB_W'(off_sum);
    // subtract: the complement form already holds one extra second
    if (stg_neg) sec_fix = off_ovf ? '0 : '1;
    else         sec_fix = {{(SEC_W-1){1'b0}}, off_ovf};
    off_sec  = base_sec + stg_sec + sec_fix;

    tick_sum = {1'b0, sub_q} + {{(LW-INC_W){1'b0}}, inc};
    tick_ovf = tick_sum >= lim;
    tick_sub = tick_ovf ? SUB_W'(tick_sum - lim) : SUB_W'(tick_sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (ld_upd) begin
      sec_q <= off_sec;
      sub_q <= off_sub;
    end else if (ld_init) begin
      sec_q <= stg_sec;
      sub_q <= stg_sub;
    end else if (tick) begin
      sub_q <= tick_sub;
      if (tick_ovf) sec_q <= sec_q + 1'b1;
    end
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int unsigned     DATA_W  = 32,
  parameter int unsigned     SEC_W   = 32,
  parameter int unsigned     SUB_W   = 31,
  parameter int unsigned     ACC_W   = 32,
  parameter int unsigned     INC_W   = 8,
  parameter int unsigned     INC_LSB = 16,
  parameter longint unsigned DIG_LIM = 1000000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SUB_W-1:0]  subsec_o,
  output logic [2:0]        cmd_pending_o
);
  logic             fine_q, dig_q, stg_neg, tick;
  logic [SEC_W-1:0] stg_sec;
  logic [SUB_W-1:0] stg_sub;
  logic [ACC_W-1:0] stg_addend;
  logic [INC_W-1:0] inc_q;
  cmd_t             pend_q;

  ptp_tc_regs #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .SUB_W(SUB_W),
    .ACC_W(ACC_W), .INC_W(INC_W), .INC_LSB(INC_LSB)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fine_q(fine_q), .dig_q(dig_q), .stg_sec(stg_sec), .stg_sub(stg_sub),
    .stg_neg(stg_neg), .stg_addend(stg_addend), .inc_q(inc_q), .pend_q(pend_q)
  );

  ptp_tc_rate #(.ACC_W(ACC_W)) u_rate (
    .clk(clk), .rst(rst), .fine(fine_q), .ld_addend(pend_q.addend),
    .stg_addend(stg_addend), .tick(tick)
  );

  ptp_tc_time #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .DIG_LIM(DIG_LIM)
  ) u_time (
    .clk(clk), .rst(rst), .dig(dig_q), .inc(inc_q), .tick(tick),
    .ld_init(pend_q.init), .ld_upd(pend_q.upd), .stg_sec(stg_sec),
    .stg_sub(stg_sub), .stg_neg(stg_neg), .sec_q(sec_o), .sub_q(subsec_o)
  );

  assign cmd_pending_o = pend_q;
endmodule

// File: rtl/ptp_tc_chk.sv
module ptp_tc_chk #(
  parameter int unsigned     SEC_W   = 32,
  parameter int unsigned     SUB_W   = 31,
  parameter int unsigned     INC_W   = 8,
  parameter longint unsigned DIG_LIM = 1000000000
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [SEC_W-1:0] sec_o,
  input logic [SUB_W-1:0] subsec_o,
  input logic [2:0]       cmd_pending_o,
  input logic             fine_q,
  input logic             dig_q,
  input logic [INC_W-1:0] inc_q,
  input logic             tick,
  input logic [SEC_W-1:0] stg_sec,
  input logic [SUB_W-1:0] stg_sub
);
  localparam int unsigned   LW      = SUB_W + 1;
  localparam logic [LW-1:0] LIM_DIG = LW'(DIG_LIM);
  localparam logic [LW-1:0] LIM_BIN = {1'b1, {SUB_W{1'b0}}};

  logic [LW-1:0] nxt;
  logic          idle_cmd;
  always_comb begin
    nxt      = {1'b0, subsec_o} + {{(LW-INC_W){1'b0}}, inc_q};
    idle_cmd = (cmd_pending_o == 3'b000);
  end

  // R13
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (sec_o == '0 && subsec_o == '0 && cmd_pending_o == 3'b000));

  // R6
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle_cmd && !(wr_en && wr_addr == 3'd0)) |=> idle_cmd);

  // R6
  init_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_pending_o == 3'b001) |=> (sec_o == $past(stg_sec) && subsec_o == $past(stg_sub)));

  // R3
  coarse_step_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_cmd && !fine_q && nxt < (dig_q ? LIM_DIG : LIM_BIN))
    |=> (subsec_o == $past(nxt[SUB_W-1:0]) && $stable(sec_o)));

  // R1
  fine_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_cmd && !tick) |=> ($stable(sec_o) && $stable(subsec_o)));

  // R4
  dig_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_cmd && tick && dig_q && nxt >= LIM_DIG) |=> (sec_o == $past(sec_o) + 1'b1));

  // R5
  bin_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_cmd && tick && !dig_q && nxt >= LIM_BIN) |=> (sec_o == $past(sec_o) + 1'b1));
endmodule

bind ptp_time_counter ptp_tc_chk #(
  .SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .DIG_LIM(DIG_LIM)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .sec_o(sec_o),
  .subsec_o(subsec_o), .cmd_pending_o(cmd_pending_o), .fine_q(fine_q),
  .dig_q(dig_q), .inc_q(inc_q), .tick(tick), .stg_sec(stg_sec), .stg_sub(stg_sub)
);

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  localparam logic [31:0] C_FINE = 32'h01, C_DIG = 32'h02, C_INIT = 32'h04,
                          C_UPD = 32'h08, C_ADD = 32'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] sec_o;
  logic [30:0] subsec_o;
  logic [2:0]  cmd_pending_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic cmp_en = 1'b0;

  always #2 clk = ~clk;

  ptp_time_counter u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .subsec_o(subsec_o), .cmd_pending_o(cmd_pending_o)
  );

  // ---------------- reference model (time as one total count) ----------------
  logic [31:0] m_sec, m_acc, m_act, m_sadd, m_usec, m_usub;
  logic [30:0] m_sub;
  logic [7:0]  m_inc;
  logic [2:0]  m_pend;
  logic        m_fine, m_dig;

  function automatic logic [65:0] lim_of(input logic dig);
    return dig ? 66'd1000000000 : 66'd2147483648;
  endfunction

  always @(posedge clk) begin
    logic [65:0] lim, modv, tot, dlt;
    logic [32:0] asum;
    logic [31:0] mag_s;
    if (rst) begin
      m_sec = '0; m_sub = '0; m_acc = '0; m_act = '0; m_sadd = '0;
      m_usec = '0; m_usub = '0; m_inc = '0; m_pend = '0; m_fine = 1'b0; m_dig = 1'b0;
    end else begin
      lim  = lim_of(m_dig);
      modv = lim << 32;
      asum = {1'b0, m_acc} + {1'b0, m_act};
      if (m_pend[0] || m_pend[1]) begin
        if (m_pend[0]) begin m_sec = m_usec; m_sub = m_usub[30:0]; end
        if (m_pend[1]) begin
          tot = {34'd0, m_sec} * lim + {35'd0, m_sub};
          if (!m_usub[31]) begin
            dlt = {34'd0, m_usec} * lim + {35'd0, m_usub[30:0]};
            tot = (tot + dlt) % modv;
          end else begin
            mag_s = -m_usec;
            dlt = {34'd0, mag_s} * lim + (lim - {35'd0, m_usub[30:0]});
            tot = (tot + modv - dlt) % modv;
          end
          m_sec = 32'(tot / lim);
          m_sub = 31'(tot % lim);
        end
      end else if (!m_fine || asum[32]) begin
        tot = ({34'd0, m_sec} * lim + {35'd0, m_sub} + {58'd0, m_inc}) % modv;
        m_sec = 32'(tot / lim);
        m_sub = 31'(tot % lim);
      end
      m_acc = asum[31:0];
      if (m_pend[2]) m_act = m_sadd;
      m_pend = '0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_fine = wr_data[0]; m_dig = wr_data[1]; m_pend = wr_data[4:2]; end
          3'd1: m_usec = wr_data;
          3'd2: m_usub = wr_data;
          3'd3: m_sadd = wr_data;
          3'd4: m_inc  = wr_data[23:16];
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_t(input string tag, input logic [31:0] es, input logic [30:0] en);
    chk({tag, " seconds"}, 64'(sec_o), 64'(es));
    chk({tag, " subsec"}, 64'(subsec_o), 64'(en));
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3 model seconds", 64'(sec_o), 64'(m_sec));
      chk("R8 model subsec", 64'(subsec_o), 64'(m_sub));
      chk("R6 model pending", 64'(cmd_pending_o), 64'(m_pend));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] mode, limv;
    void'($urandom(32'd20240611));
    idle(3);
    rst = 1'b0;
    idle(1);
    // R13 reset state
    chk_t("R13 reset", 32'd0, 31'd0);
    chk("R13 reset pending", 64'(cmd_pending_o), 64'd0);

    // digital wrap, coarse stepping, increment field (R4 R3 R6 R10)
    wr(3'd2, 32'd999_999_990);
    wr(3'd1, 32'd5);
    wr(3'd0, C_DIG | C_INIT);
    chk("R6 init pending", 64'(cmd_pending_o), 64'd1);
    wr(3'd4, 32'hAA08_55FF);
    chk_t("R6 init load", 32'd5, 31'd999_999_990);
    chk("R6 pending cleared", 64'(cmd_pending_o), 64'd0);
    idle(1);
    chk_t("R10 R3 coarse step", 32'd5, 31'd999_999_998);
    idle(1);
    chk_t("R4 digital wrap", 32'd6, 31'd6);

    // binary wrap (R5)
    wr(3'd2, 32'h7FFF_FFF0);
    wr(3'd1, 32'd9);
    wr(3'd0, C_INIT);
    idle(1);
    chk_t("R6 binary load", 32'd9, 31'h7FFF_FFF0);
    idle(1);
    chk_t("R5 binary step", 32'd9, 31'h7FFF_FFF8);
    idle(1);
    chk_t("R5 binary wrap", 32'd10, 31'd0);

    // offset add with carry (R8)
    wr(3'd2, 32'd999_999_000);
    wr(3'd1, 32'd100);
    wr(3'd0, C_DIG | C_INIT);
    wr(3'd4, 32'd0);
    chk_t("R6 load before offset", 32'd100, 31'd999_999_000);
    wr(3'd1, 32'd3);
    wr(3'd2, 32'd2000);
    wr(3'd0, C_DIG | C_UPD);
    chk("R8 update pending", 64'(cmd_pending_o), 64'd2);
    idle(1);
    chk_t("R8 add with carry", 32'd104, 31'd1000);

    // subtract with borrow (R9): minus 4 s 2000 ns
    wr(3'd1, 32'hFFFF_FFFC);
    wr(3'd2, 32'h8000_0000 | 32'd999_998_000);
    wr(3'd0, C_DIG | C_UPD);
    idle(1);
    chk_t("R9 subtract borrow", 32'd99, 31'd999_999_000);

    // seconds wrap (R11)
    wr(3'd2, 32'd999_999_999);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, C_DIG | C_INIT);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd1);
    wr(3'd0, C_DIG | C_UPD);
    idle(1);
    chk_t("R11 seconds wrap", 32'd0, 31'd0);

    // ordering init then update in one write (R12)
    wr(3'd1, 32'd10);
    wr(3'd2, 32'd5);
    wr(3'd0, C_DIG | C_INIT | C_UPD);
    chk("R12 both pending", 64'(cmd_pending_o), 64'd3);
    idle(1);
    chk_t("R12 load then add", 32'd20, 31'd10);

    // fine mode, mid-range addend (R1 R2 R7)
    wr(3'd3, 32'h8000_0000);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd4, 32'h0004_0000);
    wr(3'd0, C_DIG | C_FINE | C_INIT | C_ADD);
    chk("R7 init+addend pending", 64'(cmd_pending_o), 64'd5);
    idle(1);
    chk_t("R12 fine load", 32'd0, 31'd0);
    idle(1);
    chk_t("R1 no carry hold", 32'd0, 31'd0);
    idle(1);
    chk_t("R2 carry step", 32'd0, 31'd4);
    idle(2);
    chk_t("R2 half rate", 32'd0, 31'd8);
    wr(3'd3, 32'hFFFF_FFFF);
    idle(4);
    chk_t("R7 staged addend inert", 32'd0, 31'd16);
    wr(3'd0, C_DIG | C_FINE | C_ADD);
    chk("R7 addend pending", 64'(cmd_pending_o), 64'd4);
    idle(1);
    chk_t("R7 copy edge", 32'd0, 31'd20);
    chk("R7 pending cleared", 64'(cmd_pending_o), 64'd0);
    idle(2);
    chk_t("R7 new rate", 32'd0, 31'd28);

    // random phases in every mode against the model
    cmp_en = 1'b1;
    for (int ph = 0; ph < 4; ph++) begin
      mode = {30'd0, ph[1], ph[0]};
      limv = mode[1] ? 32'd1000000000 : 32'h8000_0000;
      wr(3'd1, $urandom);
      wr(3'd2, $urandom % limv);
      wr(3'd0, mode | C_INIT);
      for (int i = 0; i < 500; i++) begin
        if ($urandom_range(9) < 3) begin
          case ($urandom_range(4))
            0: wr(3'd0, mode | (32'($urandom_range(7)) << 2));
            1: wr(3'd1, $urandom);
            2: wr(3'd2, {1'($urandom_range(1)), 31'($urandom % limv)});
            3: wr(3'd3, $urandom);
            default: wr(3'd4, $urandom);
          endcase
        end else begin
          idle(1);
        end
      end
    end
    cmp_en = 1'b0;
    summary();
  end
endmodule